// File: doc/BRIEF.md
# Multi-Error Sector Correction Sequencer

This block drives an external error-locator unit through the correction of one 512-byte sector after that sector has been read from flash. A `go` pulse captures eight 10-bit check values, which were stored when the sector was written. The block hands these values to the locator one per cycle, highest index first. It then looks at the syndrome the locator produces. A zero syndrome ends the job at once with nothing to fix. Otherwise the block clears stale locator results, starts the locator and waits until the locator has really finished.

Once the locator reports that addresses are ready, the sequencer walks through up to four error records. Each record is an address half and a value half taken from one of two shared 32-bit result registers. The raw address is mirrored into a byte offset. Only offsets inside the data area are repaired, by a read, XOR, write sequence on a simple sector-buffer port. A one-cycle `done` pulse reports either the number of bytes repaired or that the sector cannot be corrected.

Top module: `ecc_seq_ctrl`

## Requirements
- R1: After `go`, `ld_valid` is high for exactly eight consecutive cycles, and `ld_data` carries the captured check values with index 7 first, down to index 0. Value k sits at bits [10k+9:10k] of `chk_vals`.
- R2: If all syndrome words are zero after loading, `done` follows the next cycle with `corr_cnt`=0 and `uncorr`=0. In that case `calc_start` is never raised and the buffer is never written.
- R3: For a non-zero syndrome, `clr_rd` pulses exactly once, and `calc_start` pulses in the following cycle.
- R4: After `calc_start`, a locator state below 4 is not acted on until either a state of 4 or more has been seen or `GUARD_CYC` cycles have passed. Once the timeout expires, polling continues normally.
- R5: Locator state encoding: 0 ends with zero corrections, 1 ends with `uncorr`=1 and no buffer writes, 2 or 3 means the results are ready, and 4 to 15 means busy.
- R6: The number of error records processed is 1 plus `loc_cnt`.
- R7: Records 0 and 1 come from register pair 0 (bits [31:0] of `err_addr_regs`/`err_val_regs`), and records 2 and 3 from pair 1 (bits [63:32]). Odd records use the upper 16-bit half and even records the lower half. The raw address is bits [9:0] of the half and the value is bits [7:0].
- R8: The byte offset is 519 minus the raw address. Only offsets from 0 to 511 are repaired; all other records leave the buffer unchanged.
- R9: Each repair drives `mem_re` with the offset, and in the next cycle drives `mem_we` to the same address with `mem_rdata` XOR the error value.
- R10: `corr_cnt` counts only the records that fell inside the data area.
- R11: After reset, `done`, `ld_valid`, `clr_rd`, `calc_start`, `mem_re` and `mem_we` are all low until `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start one sector correction |
| chk_vals | input | 80 | Eight stored 10-bit check values |
| ld_valid | output | 1 | Check value strobe to the locator |
| ld_data | output | 10 | Check value being loaded |
| syn_words | input | 128 | Four syndrome words from the locator |
| clr_rd | output | 1 | Dummy read that clears old locator results |
| calc_start | output | 1 | Start the error-address calculation |
| loc_state | input | 4 | Locator state field |
| loc_cnt | input | 2 | Error count field (count minus one) |
| err_addr_regs | input | 64 | Two error-address registers, two halves each |
| err_val_regs | input | 64 | Two error-value registers, two halves each |
| mem_re | output | 1 | Sector buffer read strobe |
| mem_we | output | 1 | Sector buffer write strobe |
| mem_addr | output | 9 | Sector buffer byte address |
| mem_wdata | output | 8 | Corrected byte |
| mem_rdata | input | 8 | Byte read, valid one cycle after `mem_re` |
| done | output | 1 | Completion pulse |
| corr_cnt | output | 3 | Bytes repaired |
| uncorr | output | 1 | Sector cannot be corrected |

## Verification
The assertions assume that the locator holds its state, count and result registers steady while the sequencer is polling and repairing, and that the buffer returns read data exactly one cycle after a read strobe. The stub in the bench keeps to these assumptions: it changes its outputs only in response to `calc_start` and `clr_rd`. While it is still working, it shows a misleading "complete" state together with stale result values. The guard and the timeout are exercised as two separate schedules. Duplicate offsets and offsets outside the data area are included so that the read, XOR, write path and the filter are both visible in the final buffer contents.

// File: rtl/ecc_seq_pkg.sv
package ecc_seq_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_LOAD,
      S_SYN,
      S_CLR,
      S_START,
      S_GUARD,
      S_POLL,
      S_FIXRD,
      S_FIXWR,
      S_DONE
   } seq_st_t;

   localparam int          LOC_W        = 4;
   localparam logic [3:0]  LOC_CLEAN    = 4'd0;
   localparam logic [3:0]  LOC_FAIL     = 4'd1;
   localparam logic [3:0]  LOC_BUSY_MIN = 4'd4;
   localparam int          MAX_ERR      = 4;
   localparam int          CNT_W        = 3;

endpackage

// File: rtl/ecc_seq_guard.sv
module ecc_seq_guard #(
   parameter int LIMIT = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic run,
   output logic expired
);

   if (LIMIT < 0) begin : g_bad
      $error("ecc_seq_guard: LIMIT must not be negative");
   end

   if (LIMIT == 0) begin : g_none
      // no timeout: the guard phase ends only on a busy state
      assign expired = 1'b0;
   end else begin : g_cnt
      localparam int TW = $clog2(LIMIT + 1);
      logic [TW-1:0] tick;

      always_ff @(posedge clk) begin
         if (!rst_n)
            tick <= '0;
         else if (arm)
            tick <= '0;
         else if (run && tick != TW'(LIMIT))
            tick <= tick + 1'b1;
      end

      assign expired = (tick == TW'(LIMIT));

      // R4
      tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (expired && run && !arm) |=> expired);
   end

endmodule

// File: rtl/ecc_seq_pick.sv
module ecc_seq_pick #(
   parameter int REG_W  = 32,
   parameter int RAW_W  = 10,
   parameter int DATA_W = 8,
   parameter int SECTOR = 512,
   parameter int OFF_W  = 9
) (
   input  logic [1:0]          idx,
   input  logic [2*REG_W-1:0]  addr_regs,
   input  logic [2*REG_W-1:0]  val_regs,
   output logic [OFF_W-1:0]    off,
   output logic [DATA_W-1:0]   val,
   output logic                hit
);

   localparam int HALF   = REG_W / 2;
   localparam int MIRROR = SECTOR + 7;
   localparam int MW     = RAW_W + 1;

   if (REG_W % 2 != 0 || RAW_W > HALF || DATA_W > HALF) begin : g_bad_w
      $error("ecc_seq_pick: a record field does not fit in half a register");
   end
   if (MW <= OFF_W || MIRROR >= (1 << MW)) begin : g_bad_m
      $error("ecc_seq_pick: raw address too narrow for the mirror");
   end

   logic [MW-1:0] raw_ext;
   logic [MW-1:0] diff;
   logic [MW-1:0] mir;
   logic          unused_bits;

   assign mir = MW'(MIRROR);

   always_comb begin
      int base;
      base    = int'(idx[1]) * REG_W + int'(idx[0]) * HALF;
      raw_ext = {1'b0, addr_regs[base +: RAW_W]};
      val     = val_regs[base +: DATA_W];
   end

   assign diff = mir - raw_ext;
   assign hit  = (raw_ext <= mir) && (diff < MW'(SECTOR));
   assign off  = diff[OFF_W-1:0];

   assign unused_bits = ^{addr_regs, val_regs, diff[MW-1:OFF_W]};

endmodule

// File: rtl/ecc_seq_ctrl.sv
module ecc_seq_ctrl
   import ecc_seq_pkg::*;
#(
   parameter int CHK_W     = 10,
   parameter int NCHK      = 8,
   parameter int REG_W     = 32,
   parameter int NSYN      = 4,
   parameter int SECTOR    = 512,
   parameter int DATA_W    = 8,
   parameter int GUARD_CYC = 10000,
   localparam int OFF_W    = $clog2(SECTOR)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   go,
   input  logic [NCHK*CHK_W-1:0]  chk_vals,
   output logic                   ld_valid,
   output logic [CHK_W-1:0]       ld_data,
   input  logic [NSYN*REG_W-1:0]  syn_words,
   output logic                   clr_rd,
   output logic                   calc_start,
   input  logic [LOC_W-1:0]       loc_state,
   input  logic [1:0]             loc_cnt,
   input  logic [2*REG_W-1:0]     err_addr_regs,
   input  logic [2*REG_W-1:0]     err_val_regs,
   output logic                   mem_re,
   output logic                   mem_we,
   output logic [OFF_W-1:0]       mem_addr,
   output logic [DATA_W-1:0]      mem_wdata,
   input  logic [DATA_W-1:0]      mem_rdata,
   output logic                   done,
   output logic [CNT_W-1:0]       corr_cnt,
   output logic                   uncorr
);

   localparam int LIW = $clog2(NCHK);

   if (NCHK < 2 || (1 << LIW) != NCHK) begin : g_bad_n
      $error("ecc_seq_ctrl: NCHK must be a power of two");
   end
   if ((1 << OFF_W) != SECTOR) begin : g_bad_s
      $error("ecc_seq_ctrl: SECTOR must be a power of two");
   end

   seq_st_t                st;
   logic [LIW-1:0]         ld_idx;
   logic [NCHK*CHK_W-1:0]  chk_q;
   logic [1:0]             err_i;
   logic [CNT_W-1:0]       err_n;
   logic [CNT_W-1:0]       corr;
   logic                   unc;
   logic [OFF_W-1:0]       wr_addr;
   logic [DATA_W-1:0]      wr_val;
   logic [OFF_W-1:0]       pk_off;
   logic [DATA_W-1:0]      pk_val;
   logic                   pk_hit;
   logic                   tmo;
   logic                   syn_zero;
   logic                   last;

   assign syn_zero = (syn_words == '0);
   assign last     = ({1'b0, err_i} == err_n - 3'd1);

   ecc_seq_pick #(
      .REG_W (REG_W),
      .RAW_W (CHK_W),
      .DATA_W(DATA_W),
      .SECTOR(SECTOR),
      .OFF_W (OFF_W)
   ) u_pick (
      .idx      (err_i),
      .addr_regs(err_addr_regs),
      .val_regs (err_val_regs),
      .off      (pk_off),
      .val      (pk_val),
      .hit      (pk_hit)
   );

   ecc_seq_guard #(
      .LIMIT(GUARD_CYC)
   ) u_guard (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (calc_start),
      .run    (st == S_GUARD),
      .expired(tmo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         ld_idx  <= '0;
         chk_q   <= '0;
         err_i   <= '0;
         err_n   <= '0;
         corr    <= '0;
         unc     <= 1'b0;
         wr_addr <= '0;
         wr_val  <= '0;
      end else begin
         case (st)
            S_IDLE: if (go) begin
               chk_q  <= chk_vals;
               ld_idx <= LIW'(NCHK - 1);
               corr   <= '0;
               unc    <= 1'b0;
               st     <= S_LOAD;
            end
            S_LOAD: begin
               if (ld_idx == '0) st <= S_SYN;
               else              ld_idx <= ld_idx - 1'b1;
            end
            S_SYN:   st <= syn_zero ? S_DONE : S_CLR;
            S_CLR:   st <= S_START;
            S_START: st <= S_GUARD;
            S_GUARD: if (loc_state >= LOC_BUSY_MIN || tmo) st <= S_POLL;
            S_POLL: begin
               if (loc_state == LOC_CLEAN) begin
                  st <= S_DONE;
               end else if (loc_state == LOC_FAIL) begin
                  unc <= 1'b1;
                  st  <= S_DONE;
               end else if (loc_state < LOC_BUSY_MIN) begin
                  err_n <= 3'd1 + {1'b0, loc_cnt};
                  err_i <= '0;
                  st    <= S_FIXRD;
               end
            end
            S_FIXRD: begin
               if (pk_hit) begin
                  wr_addr <= pk_off;
                  wr_val  <= pk_val;
                  st      <= S_FIXWR;
               end else if (last) begin
                  st <= S_DONE;
               end else begin
                  err_i <= err_i + 1'b1;
               end
            end
            S_FIXWR: begin
               corr <= corr + 1'b1;
               if (last) begin
                  st <= S_DONE;
               end else begin
                  err_i <= err_i + 1'b1;
                  st    <= S_FIXRD;
               end
            end
            S_DONE:  st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign ld_valid   = (st == S_LOAD);
   assign ld_data    = chk_q[int'(ld_idx) * CHK_W +: CHK_W];
   assign clr_rd     = (st == S_CLR);
   assign calc_start = (st == S_START);
   assign mem_re     = (st == S_FIXRD) && pk_hit;
   assign mem_we     = (st == S_FIXWR);
   assign mem_addr   = (st == S_FIXWR) ? wr_addr : pk_off;
   assign mem_wdata  = mem_rdata ^ wr_val;
   assign done       = (st == S_DONE);
   assign corr_cnt   = corr;
   assign uncorr     = unc;

   // R1
   load_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && $past(ld_valid)) |-> (ld_idx == $past(ld_idx) - 1'b1));

   // R2
   clean_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_SYN && syn_zero) |=> (done && corr_cnt == '0 && !uncorr));

   // R3
   clr_before_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      calc_start |-> $past(clr_rd));

   // R4
   guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_GUARD && loc_state < LOC_BUSY_MIN && !tmo) |=> (st == S_GUARD));

   // R5
   unc_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && uncorr) |-> (corr_cnt == '0));

   // R9
   rmw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(mem_re) && mem_addr == $past(mem_addr)));

   // R10
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (corr_cnt <= err_n || corr_cnt == '0));

endmodule

// File: tb/ecc_seq_ctrl_tb.sv
module ecc_seq_ctrl_tb;

   localparam int CHK_W  = 10;
   localparam int NCHK   = 8;
   localparam int REG_W  = 32;
   localparam int NSYN   = 4;
   localparam int SECTOR = 512;
   localparam int DATA_W = 8;
   localparam int GUARD  = 40;
   localparam int OFF_W  = 9;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   go = 1'b0;
   logic [NCHK*CHK_W-1:0]  chk_vals = '0;
   logic                   ld_valid;
   logic [CHK_W-1:0]       ld_data;
   logic [NSYN*REG_W-1:0]  syn_words;
   logic                   clr_rd;
   logic                   calc_start;
   logic [3:0]             loc_state;
   logic [1:0]             loc_cnt;
   logic [2*REG_W-1:0]     err_addr_regs;
   logic [2*REG_W-1:0]     err_val_regs;
   logic                   mem_re;
   logic                   mem_we;
   logic [OFF_W-1:0]       mem_addr;
   logic [DATA_W-1:0]      mem_wdata;
   logic [DATA_W-1:0]      mem_rdata;
   logic                   done;
   logic [2:0]             corr_cnt;
   logic                   uncorr;

   always #5 clk = ~clk;

   ecc_seq_ctrl #(
      .CHK_W(CHK_W), .NCHK(NCHK), .REG_W(REG_W), .NSYN(NSYN),
      .SECTOR(SECTOR), .DATA_W(DATA_W), .GUARD_CYC(GUARD)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .go(go), .chk_vals(chk_vals),
      .ld_valid(ld_valid), .ld_data(ld_data), .syn_words(syn_words),
      .clr_rd(clr_rd), .calc_start(calc_start), .loc_state(loc_state),
      .loc_cnt(loc_cnt), .err_addr_regs(err_addr_regs),
      .err_val_regs(err_val_regs), .mem_re(mem_re), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .done(done), .corr_cnt(corr_cnt), .uncorr(uncorr)
   );

   // ---------------- sector buffer ----------------
   logic [7:0] mem     [SECTOR];
   logic [7:0] exp_mem [SECTOR];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < SECTOR; k++) mem[k] <= 8'((k * 13 + 5) & 255);
         mem_rdata <= '0;
      end else begin
         if (mem_re) mem_rdata <= mem[mem_addr];
         if (mem_we) mem[mem_addr] <= mem_wdata;
      end
   end

   // ---------------- locator stub ----------------
   int          cfg_glitch = 0;
   int          cfg_busy   = 0;
   logic [3:0]  cfg_final  = 4'd2;
   logic [1:0]  cfg_cnt    = 2'd0;
   logic        cfg_hold   = 1'b0;
   logic        cfg_synz   = 1'b1;
   logic [63:0] cfg_addr   = '0;
   logic [63:0] cfg_val    = '0;
   logic        active;
   int          ph;
   logic        ready;

   always @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         ph     <= 0;
      end else if (calc_start) begin
         active <= 1'b1;
         ph     <= 0;
      end else if (clr_rd) begin
         active <= 1'b0;
      end else if (active && ph < 100000) begin
         ph <= ph + 1;
      end
   end

   assign ready = cfg_hold || (active && ph >= cfg_glitch + cfg_busy);

   always_comb begin
      if (!active)                          loc_state = 4'd3;
      else if (cfg_hold)                    loc_state = cfg_final;
      else if (ph < cfg_glitch)             loc_state = 4'd3;
      else if (ph < cfg_glitch + cfg_busy)  loc_state = 4'd9;
      else                                  loc_state = cfg_final;
   end

   assign err_addr_regs = ready ? cfg_addr : {4{16'h0207}};
   assign err_val_regs  = ready ? cfg_val  : {4{16'h00FF}};
   assign loc_cnt       = ready ? cfg_cnt  : 2'd0;
   assign syn_words     = cfg_synz ? '0 : {NSYN{32'h0001_0203}};

   // ---------------- bookkeeping ----------------
   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   int clr_n, start_n, we_n, t_start, t_first, done_n;
   logic [CHK_W-1:0] ld_q[$];
   int               res_cnt_q[$];
   bit               res_unc_q[$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: scoreboard pops
   always @(negedge clk) begin
      if (rst_n) begin
         if (clr_rd) clr_n++;
         if (calc_start) begin
            start_n++;
            t_start = cyc;
            t_first = -1;
         end
         if ((mem_re || done) && t_first < 0 && start_n > 0) t_first = cyc;
         if (mem_we) we_n++;
         if (ld_valid) begin
            if (ld_q.size() == 0) begin
               check(1'b0, "R1 unexpected load strobe", int'(ld_data), -1);
            end else begin
               logic [CHK_W-1:0] e;
               e = ld_q.pop_front();
               check(ld_data == e, "R1 load order", int'(ld_data), int'(e));
            end
         end
         if (done) begin
            done_n++;
            if (res_cnt_q.size() == 0) begin
               check(1'b0, "R10 unexpected done", int'(corr_cnt), -1);
            end else begin
               int ec;
               bit eu;
               ec = res_cnt_q.pop_front();
               eu = res_unc_q.pop_front();
               check(int'(corr_cnt) == ec, "R6 R10 corrected count", int'(corr_cnt), ec);
               check(uncorr == eu, "R5 uncorrectable flag", int'(uncorr), int'(eu));
            end
         end
      end
   end

   // driver
   task automatic run_case(input int id, input bit synz, input int g, input int b,
                           input logic [3:0] fin, input bit hold, input int n,
                           input int raw[4], input int vv[4]);
      int  exp_cnt;
      bit  exp_unc;
      int  mism;
      int  d0;
      cfg_synz   = synz;
      cfg_glitch = g;
      cfg_busy   = b;
      cfg_final  = fin;
      cfg_hold   = hold;
      cfg_cnt    = 2'(n - 1);
      cfg_addr   = '0;
      cfg_val    = '0;
      for (int i = 0; i < 4; i++) begin
         cfg_addr[(i / 2) * 32 + (i % 2) * 16 +: 16] = 16'(raw[i]);
         cfg_val [(i / 2) * 32 + (i % 2) * 16 +: 16] = 16'(vv[i]);
      end
      exp_cnt = 0;
      exp_unc = 1'b0;
      if (!synz && fin == 4'd1) begin
         exp_unc = 1'b1;
      end else if (!synz && fin >= 4'd2) begin
         for (int i = 0; i < n; i++) begin
            int off;
            off = 519 - raw[i];
            if (off >= 0 && off < 512) begin
               exp_mem[off] = exp_mem[off] ^ 8'(vv[i]);
               exp_cnt++;
            end
         end
      end
      for (int k = 0; k < NCHK; k++)
         chk_vals[k * CHK_W +: CHK_W] = CHK_W'((id * 37 + k * 101 + 3) & 1023);
      for (int k = NCHK - 1; k >= 0; k--) ld_q.push_back(chk_vals[k * CHK_W +: CHK_W]);
      res_cnt_q.push_back(exp_cnt);
      res_unc_q.push_back(exp_unc);
      clr_n   = 0;
      start_n = 0;
      we_n    = 0;
      t_start = 0;
      t_first = -1;
      d0      = done_n;
      @(negedge clk) go = 1'b1;
      @(negedge clk) go = 1'b0;
      while (done_n == d0) @(negedge clk);
      repeat (3) @(negedge clk);
      mism = 0;
      for (int k = 0; k < SECTOR; k++) if (mem[k] !== exp_mem[k]) mism++;
      check(mism == 0, "R8 R9 sector contents", mism, 0);
      check(ld_q.size() == 0, "R1 eight loads", ld_q.size(), 0);
      if (synz) begin
         check(start_n == 0, "R2 no locator start", start_n, 0);
         check(we_n == 0, "R2 no buffer write", we_n, 0);
      end else begin
         check(clr_n == 1, "R3 one clearing read", clr_n, 1);
         check(start_n == 1, "R3 one start", start_n, 1);
         if (fin < 4'd2) begin
            check(we_n == 0, "R5 no buffer write", we_n, 0);
         end else if (hold) begin
            check(t_first - t_start >= GUARD, "R4 timeout wait", t_first - t_start, GUARD);
         end else begin
            check(t_first - t_start > g + b, "R4 guard wait", t_first - t_start, g + b + 1);
         end
      end
   endtask

   initial begin
      for (int k = 0; k < SECTOR; k++) exp_mem[k] = 8'((k * 13 + 5) & 255);
      clr_n = 0; start_n = 0; we_n = 0; t_start = 0; t_first = -1; done_n = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R11 idle after reset
      check(!done && !ld_valid && !clr_rd, "R11 idle strobes", int'({done, ld_valid, clr_rd}), 0);
      check(!calc_start && !mem_re && !mem_we, "R11 idle bus", int'({calc_start, mem_re, mem_we}), 0);
      // R2 clean sector
      run_case(1, 1'b1, 4, 20, 4'd2, 1'b0, 1, '{519, 0, 0, 0}, '{8'h5A, 0, 0, 0});
      // R8 boundary offset 0
      run_case(2, 1'b0, 4, 20, 4'd2, 1'b0, 1, '{519, 0, 0, 0}, '{8'h5A, 0, 0, 0});
      // R7 four records across both pairs and halves, offset 511 included
      run_case(3, 1'b0, 3, 15, 4'd3, 1'b0, 4, '{8, 300, 100, 450}, '{8'h01, 8'h80, 8'h3C, 8'hC3});
      // R8 R10 out-of-range records filtered
      run_case(4, 1'b0, 5, 10, 4'd2, 1'b0, 3, '{7, 700, 19, 0}, '{8'h11, 8'h22, 8'h44, 0});
      // R5 state 1: uncorrectable
      run_case(5, 1'b0, 4, 12, 4'd1, 1'b0, 2, '{100, 200, 0, 0}, '{8'h0F, 8'hF0, 0, 0});
      // R5 state 0: nothing to fix
      run_case(6, 1'b0, 4, 12, 4'd0, 1'b0, 2, '{100, 200, 0, 0}, '{8'h0F, 8'hF0, 0, 0});
      // R4 timeout path: locator never shows busy
      run_case(7, 1'b0, 0, 0, 4'd3, 1'b1, 2, '{200, 201, 0, 0}, '{8'h0F, 8'hF0, 0, 0});
      // R9 two records on the same byte
      run_case(8, 1'b0, 2, 8, 4'd2, 1'b0, 2, '{400, 400, 0, 0}, '{8'h03, 8'h05, 0, 0});
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 10);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule